// File: doc/BRIEF.md
# Three-Wire Half-Duplex Transaction Master

This block runs one register-sized transaction at a time on a three-wire serial bus made of an active-low chip select, a serial clock and a single data line that carries both directions. A host presents a request (direction, address-increment flag, function number, address, byte count of 1 to 4, write data and a byte-swap mode flag). The block packs a 32-bit command word and shifts it out. It then either shifts out the write word, or releases the data line and shifts in the read word. When the frame ends it returns the result with a one-cycle completion pulse.

The serial clock runs at a programmable rate. Each half period lasts `div + 1` system cycles, and `div` is captured when a request is accepted. Every payload is padded to a full 32-bit word. Reads from the backplane function (function 1) first shift in and drop one word of response delay. A swap mode exchanges the two bytes inside each 16-bit half of both the command word and the data word. A host uses this mode to talk to a target that has not yet been set up for 32-bit word order.

The data line is presented as three on-chip signals: output value, output enable and input value. A pad or a testbench joins them into the shared wire.

Top module: `gspi_txn_master`

## Requirements
- R1: The command word is {write flag [31], increment flag [30], function [29:28], address [27:11], byte count [10:0]}. The byte count comes from `req_len`, zero-extended.
- R2: A 32-bit word goes out as four bytes with the least significant byte first. Each byte is sent most significant bit first, so serial bit k carries word bit 8*(k/8)+7-(k%8). The data output changes only while the serial clock is low. Input is sampled at the rising clock edge.
- R3: Each clock half period is `div+1` system cycles. The clock is low whenever chip select is high. A frame of N bits raises `done` exactly 1 + 2N(div+1) + (div+1) cycles after the cycle in which the request was driven.
- R4: A read with function 1 has 96 clock pulses: 32 for the command, 32 for response delay that is discarded, and 32 for data. Every other read and every write has 64 clock pulses.
- R5: Bytes at or above `req_len` are filler. On writes they go out as zero. On reads they are returned as zero in `rd_data`.
- R6: With `req_swap` set, the command word and the data word on the wire both have their bytes exchanged within each 16-bit half, ((x & 0xFF00FF00) >> 8) | ((x & 0x00FF00FF) << 8). Read data is swapped back before it is returned.
- R7: Chip select goes low when a request is accepted and stays low until half a clock period after the last clock pulse. It rises in the same cycle that `done` is high.
- R8: `spi_oe` is high only during the command bits and the write data bits. It is low during the response delay and during the read data bits.
- R9: `req_ready` is high only while no frame is active. A request presented while busy is ignored: it starts no frame and does not change the frame in progress.
- R10: `done` lasts one cycle. With it, `rd_data` holds the read result, or zero after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div | input | DIV_W | Half-period length minus one, in system cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request accepted when both valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_incr | input | 1 | Address-increment flag copied into the command |
| req_func | input | 2 | Function number (0 bus, 1 backplane, 2 and 3 data channels) |
| req_addr | input | 17 | Register address |
| req_len | input | LEN_W | Byte count, 1 to 4 |
| req_wdata | input | 32 | Write word, byte 0 in bits 7:0 |
| req_swap | input | 1 | Exchange bytes within each 16-bit half |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Read result, valid with done |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_clk | output | 1 | Serial clock |
| spi_dout | output | 1 | Data line output value |
| spi_oe | output | 1 | Data line output enable |
| spi_din | input | 1 | Data line input value |

## Verification
The bench issues a request at a falling clock edge and then counts system cycles until it sees `done`. The count must equal 1 + 2N(div+1) + (div+1), where N is 64, or 96 for a function-1 read, and any other count is reported as an error. A target model in the bench drives the input bit for the next rising edge right after each rising serial edge, so that bit is settled a full half period before the block samples it. The same model records the output value and the output enable at every rising edge. All checks on `rd_data`, `spi_cs_n` and the pulse width are made at falling system-clock edges: in the `done` cycle, and one cycle after it.

// File: rtl/gspi_txn_master.sv
module gspi_txn_master #(
  parameter int DIV_W = 8,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_incr,
  input  logic [1:0]       req_func,
  input  logic [16:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [31:0]      req_wdata,
  input  logic             req_swap,
  output logic             done,
  output logic [31:0]      rd_data,
  output logic             spi_cs_n,
  output logic             spi_clk,
  output logic             spi_dout,
  output logic             spi_oe,
  input  logic             spi_din
);

  localparam int LENF_W = 11;
  localparam int NBYTES = 4;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DLY, S_DATA, S_END} st_t;

  st_t              st;
  logic [DIV_W-1:0] div_q, cnt;
  logic [4:0]       bitk;
  logic [31:0]      cmd_q, wd_q, rsh;
  logic             rd_q, swap_q;
  logic [1:0]       func_q;
  logic [LEN_W-1:0] len_q;

  function automatic logic [31:0] sw16(input logic [31:0] x);
    return ((x & 32'hFF00FF00) >> 8) | ((x & 32'h00FF00FF) << 8);
  endfunction

  function automatic logic [31:0] bmask(input logic [LEN_W-1:0] n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NBYTES; i++)
      if (i < int'(n)) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  wire [4:0]  idx      = {bitk[4:3], ~bitk[2:0]};
  wire        half_end = (cnt == div_q);
  wire [31:0] cmd_w    = {req_write, req_incr, req_func, req_addr,
                          {(LENF_W-LEN_W){1'b0}}, req_len};
  wire [31:0] wd_m     = req_wdata & bmask(req_len);
  wire [31:0] rd_word  = (swap_q ? sw16(rsh) : rsh) & bmask(len_q);

  assign req_ready = (st == S_IDLE);
  assign spi_oe    = (st == S_CMD) || (st == S_DATA && !rd_q);
  assign spi_dout  = spi_oe && ((st == S_CMD) ? cmd_q[idx] : wd_q[idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      div_q    <= '0;
      cnt      <= '0;
      bitk     <= '0;
      cmd_q    <= '0;
      wd_q     <= '0;
      rsh      <= '0;
      rd_q     <= 1'b0;
      swap_q   <= 1'b0;
      func_q   <= '0;
      len_q    <= '0;
      done     <= 1'b0;
      rd_data  <= '0;
      spi_cs_n <= 1'b1;
      spi_clk  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          div_q    <= div;
          cnt      <= '0;
          bitk     <= '0;
          rsh      <= '0;
          rd_q     <= !req_write;
          swap_q   <= req_swap;
          func_q   <= req_func;
          len_q    <= req_len;
          cmd_q    <= req_swap ? sw16(cmd_w) : cmd_w;
          wd_q     <= req_swap ? sw16(wd_m) : wd_m;
          spi_cs_n <= 1'b0;
          st       <= S_CMD;
        end
        S_END: begin
          if (half_end) begin
            spi_cs_n <= 1'b1;
            done     <= 1'b1;
            rd_data  <= rd_q ? rd_word : '0;
            st       <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (!half_end) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (!spi_clk) begin
              spi_clk <= 1'b1;
              if (st == S_DATA && rd_q) rsh[idx] <= spi_din;
            end else begin
              spi_clk <= 1'b0;
              bitk    <= bitk + 1'b1;
              if (bitk == 5'd31) begin
                case (st)
                  S_CMD:   st <= (rd_q && func_q == 2'd1) ? S_DLY : S_DATA;
                  S_DLY:   st <= S_DATA;
                  default: st <= S_END;
                endcase
              end
            end
          end
        end
      endcase
    end
  end

endmodule

module gspi_txn_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic spi_cs_n,
  input logic spi_clk,
  input logic spi_dout,
  input logic spi_oe
);

  assert_clk_low_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_clk);

  assert_dout_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_clk && $past(spi_clk)) |-> $stable(spi_dout));

  assert_oe_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_oe |-> !spi_cs_n);

  assert_done_with_cs_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && $past(!spi_cs_n)));

  assert_cs_rise_only_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> done);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);

endmodule

bind gspi_txn_master gspi_txn_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .spi_cs_n(spi_cs_n), .spi_clk(spi_clk), .spi_dout(spi_dout), .spi_oe(spi_oe)
);

// File: tb/test_gspi_txn_master.sv
`timescale 1ns/1ps
module test_gspi_txn_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_incr = 1'b0, req_swap = 1'b0;
  logic [1:0]  req_func = '0;
  logic [16:0] req_addr = '0;
  logic [2:0]  req_len = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        req_ready, done, spi_cs_n, spi_clk, spi_dout, spi_oe, spi_din;
  logic [31:0] rd_data;

  int checks = 0, failures = 0, cyc = 0, rises = 0, base = 0, oe_bad = 0;
  logic        t_rd = 1'b0;
  logic [1:0]  t_func = '0;
  logic [31:0] t_wire = '0;
  logic        cap [0:255];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  gspi_txn_master i_gspi_txn_master (.*);

  function automatic int sidx(input int k);
    return 8*(k/8) + 7 - (k%8);
  endfunction

  function automatic logic [31:0] sw16(input logic [31:0] x);
    return ((x & 32'hFF00FF00) >> 8) | ((x & 32'h00FF00FF) << 8);
  endfunction

  function automatic logic [31:0] lmask(input int n);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (i < n) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic din_for(input int r, input logic rd, input logic [1:0] f,
                                   input logic [31:0] w);
    int off;
    off = (rd && f == 2'd1) ? 64 : 32;
    if (r < 32 || !rd) return 1'b0;
    if (r < off) return 1'b1;
    if (r < off + 32) return w[sidx(r - off)];
    return 1'b0;
  endfunction

  assign spi_din = din_for(rises - base, t_rd, t_func, t_wire);

  always @(posedge spi_clk) begin
    int r;
    logic exp_oe;
    r = rises - base;
    if (r >= 0 && r < 256) cap[r] = spi_dout;
    exp_oe = (r < 32) || (!t_rd && r < 64);
    if (spi_oe !== exp_oe) oe_bad++;
    rises++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] gather(input int start);
    logic [31:0] w = '0;
    for (int k = 0; k < 32; k++) w[sidx(k)] = cap[start + k];
    return w;
  endfunction

  task automatic run(input bit w, input int f, input int l, input bit sw, input int dv,
                     input logic [16:0] a, input logic [31:0] wd, input logic [31:0] rsp,
                     input bit poke);
    int c0, to, nbits, h, r0;
    logic [31:0] ec, ew, got;
    bit cs_ok;
    @(negedge clk);
    t_rd = !w; t_func = 2'(f); t_wire = sw ? sw16(rsp) : rsp;
    base = rises; oe_bad = 0;
    div = 8'(dv); req_write = w; req_incr = 1'b1; req_func = 2'(f);
    req_addr = a; req_len = 3'(l); req_wdata = wd; req_swap = sw; req_valid = 1'b1;
    chk(req_ready === 1'b1, "R9 ready while idle", 32'(req_ready), 32'd1);
    c0 = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      req_valid = 1'b1; req_addr = ~a; req_write = !w;
      chk(req_ready === 1'b0, "R9 ready while busy", 32'(req_ready), 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    to = 0;
    while (done !== 1'b1 && to < 100000) begin @(negedge clk); to++; end
    h = dv + 1;
    nbits = (!w && f == 1) ? 96 : 64;
    chk(to < 100000, "R3 done timeout", 32'(to), 32'd0);
    chk(cyc - c0 == 1 + 2*nbits*h + h, "R3 done latency", 32'(cyc - c0), 32'(1 + 2*nbits*h + h));
    chk(spi_cs_n === 1'b1 && spi_clk === 1'b0, "R7 cs high with done", {30'd0, spi_cs_n, spi_clk}, 32'd2);
    chk(rises - base == nbits, "R4 clock pulse count", 32'(rises - base), 32'(nbits));
    chk(oe_bad == 0, "R8 output enable per bit", 32'(oe_bad), 32'd0);
    ec = {w, 1'b1, 2'(f), a, 8'd0, 3'(l)};
    if (sw) ec = sw16(ec);
    got = gather(0);
    chk(got === ec, sw ? "R6 swapped command" : "R1 command word", got, ec);
    if (w) begin
      ew = wd & lmask(l);
      if (sw) ew = sw16(ew);
      got = gather(32);
      chk(got === ew, sw ? "R6 swapped write word" : "R5 write padding", got, ew);
      chk(rd_data === 32'd0, "R10 rd_data zero after write", rd_data, 32'd0);
    end else begin
      ew = rsp & lmask(l);
      chk(rd_data === ew, (f == 1) ? "R4 read after delay word" : "R5 read masking", rd_data, ew);
    end
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", 32'(done), 32'd0);
    if (poke) begin
      r0 = rises; cs_ok = 1'b1;
      repeat (20) begin @(negedge clk); if (spi_cs_n !== 1'b1) cs_ok = 1'b0; end
      chk(cs_ok && rises == r0, "R9 busy request ignored", 32'(rises - r0), 32'd0);
    end
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_clk === 1'b0 && spi_oe === 1'b0 && req_ready === 1'b1 && done === 1'b0,
        "R3 reset state", {27'd0, spi_cs_n, spi_clk, spi_oe, req_ready, done}, 32'h12);
    for (int sw = 0; sw < 2; sw++)
      for (int w = 0; w < 2; w++)
        for (int f = 0; f < 4; f++)
          for (int l = 1; l <= 4; l++)
            run(w[0], f, l, sw[0], (f + l) % 3,
                17'(17'h10000 ^ (f*977 + l*31 + sw*4099)),
                32'h1234_5678 ^ 32'(f*32'h0101_0101 + l*32'h1111 + w*7),
                32'hFEED_BEAD ^ 32'(f*32'h0F0F + l*32'h1000_0001 + sw*32'h0300_0000),
                1'b0);
    run(1'b1, 1, 4, 1'b0, 2, 17'h0ABCD, 32'hCAFE_F00D, 32'h0, 1'b1);
    run(1'b0, 1, 4, 1'b0, 5, 17'h1000E, 32'h0, 32'h8040_2010, 1'b1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule